// File: doc/BRIEF.md
# Page Write and Completion Poll Controller for a Byte-Wide EEPROM

This block is a bus master for a byte-wide parallel EEPROM. A host issues a start command that carries a base address and a byte count from 1 to 16. The host then streams the bytes through a valid/ready handshake. The controller turns each byte into a write strobe on the memory bus. It drives address, data and active-low chip-enable, output-enable and write-enable, and every phase length is an elaboration-time cycle count. All bytes of one request land in the same 16-byte page. The low four address bits step from the base offset and wrap inside the page. The bits above them never change during the request.

The memory starts its internal programming once write strobes stop arriving. Consecutive write-enable falls therefore have to stay inside a fixed window. If the byte stream stalls past the last cycle that still meets that window, the controller stops and reports a page-break error. After the last byte it does not wait a fixed delay. It releases the data bus and runs read cycles on the last written address until bit 7 reads back as the written value, and then it pulses done. If the bit does not match within the poll limit, it reports a timeout.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, chip-enable, output-enable and write-enable are high, the data driver is off, and byte ready and busy are low.
- R2: A start with a count of 0 or above 16 gives a one-cycle error pulse with error code 1 and causes no write strobe. Error codes are: 0 none, 1 bad count, 2 page break, 3 poll timeout.
- R3: Byte k of a request is written to address {base[10:4], (base[3:0]+k) mod 16}. The upper address bits stay constant while the block is busy.
- R4: The data on the bus while write-enable is low is the k-th byte accepted from the stream, and the data driver is on.
- R5: Address and data are driven, with output-enable high, for at least T_SETUP cycles before each write-enable fall and for T_WPH cycles after each rise.
- R6: Each write-enable low pulse lasts exactly T_WPW cycles, and output-enable is never low while write-enable is low.
- R7: Within one request, consecutive write-enable falls are fewer than BLC_CYC cycles apart.
- R8: If byte k>0 is not accepted by the cycle in which its strobe could still fall inside the window, the block raises error code 2 and issues no further strobe. A stall before the first byte is never an error.
- R9: Poll reads drive chip-enable and output-enable low with write-enable high and the data driver off. The driver is off for at least one cycle before output-enable falls.
- R10: Done is a single-cycle pulse, given only after a poll read in which bit 7 equals bit 7 of the last written byte.
- R11: If the poll has not matched once POLL_LIMIT cycles have passed since polling began, the block raises error code 3 and gives no done.
- R12: A start request while the block is busy is ignored. The running page completes unchanged and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a page request (sampled when idle) |
| base_addr_i | input | 11 | Address of the first byte |
| count_i | input | 5 | Number of bytes, valid 1 to 16 |
| byte_valid_i | input | 1 | Stream byte present |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Controller accepts a byte this cycle |
| mem_addr_o | output | 11 | Memory address |
| mem_dout_o | output | 8 | Data driven toward memory |
| mem_dout_en_o | output | 1 | Data driver enable |
| mem_ce_n_o | output | 1 | Chip-enable, active low |
| mem_oe_n_o | output | 1 | Output-enable, active low |
| mem_we_n_o | output | 1 | Write-enable, active low |
| mem_din_i | input | 8 | Data read from memory |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 2 | Code of the last error, cleared by an accepted start |

## Verification
A wrong byte index or offset register shows up at the very next write strobe: the captured address or data no longer matches the stream. A stuck phase timer shows up within one pulse as a wrong write-enable width, or as a setup run shorter than T_SETUP at the fall. A bad inter-strobe window counter shows up as a page-break error one cycle early, or none at all one cycle late. The stall sweep probes both sides of that boundary. A broken poll comparison shows up either as done while the memory model is still programming or as a spurious timeout, in each case within one poll read of the moment the bit first flips.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SETUP, ST_STROBE, ST_RECOV, ST_REL, ST_READ, ST_GAP
  } pw_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_COUNT = 2'd1, ERR_BREAK = 2'd2, ERR_TIMEOUT = 2'd3
  } pw_err_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-OFF_W-1:0] page_q;
  logic [OFF_W-1:0]        off_q;

  function automatic logic [ADDR_W-1:0] compose(input logic [ADDR_W-OFF_W-1:0] pg,
                                                input logic [OFF_W-1:0] off);
    return {pg, off};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= base_i[ADDR_W-1:OFF_W];
      off_q  <= base_i[OFF_W-1:0];
    end else if (step_i) begin
      off_q  <= off_q + 1'b1;
    end
  end

  assign addr_o = compose(page_q, off_q);

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(page_q));
endmodule

// File: rtl/pw_window.sv
module pw_window #(
  parameter int LIMIT = 996,
  parameter int W     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic late_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign late_o = (cnt_q == W'(LIMIT));

  // R8
  window_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_o && !restart_i) |=> late_o);
endmodule

// File: rtl/pw_poll.sv
module pw_poll #(
  parameter int DATA_W = 8,
  parameter int LIMIT  = 500000,
  parameter int W      = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ref_msb_i,
  output logic              match_o,
  output logic              expired_o
);
  logic [W-1:0] cnt_q;

  function automatic logic msb_true(input logic [DATA_W-1:0] d, input logic r);
    return d[DATA_W-1] == r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (arm_i)              cnt_q <= '0;
    else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign match_o   = sample_i && msb_true(din_i, ref_msb_i);
  assign expired_o = (cnt_q == W'(LIMIT));

  // R11
  poll_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !expired_o);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int T_SETUP    = 3,
  parameter int T_WPW      = 5,
  parameter int T_WPH      = 3,
  parameter int T_RD       = 8,
  parameter int BLC_CYC    = 1000,
  parameter int POLL_LIMIT = 500000,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_dout_en_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int WIN_LIMIT = BLC_CYC - T_SETUP - 1;
  localparam int WIN_W     = $clog2(WIN_LIMIT + 1);
  localparam int TO_W      = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W     = $clog2(BLC_CYC + 1);
  localparam int TMAX      = max2(max2(T_SETUP, T_WPW), max2(T_WPH, T_RD));
  localparam int TMR_W     = $clog2(TMAX + 1);
  localparam int RUN_W     = $clog2(T_WPW + 2);

  pw_state_e          state_q;
  pw_err_e            code_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [CNT_W-1:0]   idx_q, cnt_q;
  logic [DATA_W-1:0]  data_q;
  logic               first_q, done_q, err_q;

  function automatic logic count_ok(input logic [CNT_W-1:0] c);
    return (c != '0) && (c <= CNT_W'(PAGE_BYTES));
  endfunction

  function automatic logic phase_done(input pw_state_e s, input logic [TMR_W-1:0] t);
    case (s)
      ST_SETUP:  return t == TMR_W'(T_SETUP - 1);
      ST_STROBE: return t == TMR_W'(T_WPW - 1);
      ST_RECOV:  return t == TMR_W'(T_WPH - 1);
      ST_READ:   return t == TMR_W'(T_RD - 1);
      default:   return 1'b1;
    endcase
  endfunction

  // named internal events
  logic tmr_end, last_byte, late, accept, load_ev, step_ev, strobe_ev;
  logic arm_ev, sample_ev, match, expired;

  assign tmr_end   = phase_done(state_q, tmr_q);
  assign last_byte = (idx_q == cnt_q - 1'b1);
  assign load_ev   = (state_q == ST_IDLE) && start_i && count_ok(count_i);
  assign accept    = (state_q == ST_WAIT) && byte_valid_i && !(late && !first_q);
  assign step_ev   = (state_q == ST_RECOV) && tmr_end && !last_byte;
  assign strobe_ev = (state_q == ST_SETUP) && tmr_end;
  assign arm_ev    = (state_q == ST_REL);
  assign sample_ev = (state_q == ST_READ) && tmr_end;

  pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(load_ev), .step_i(step_ev),
    .base_i(base_addr_i), .addr_o(mem_addr_o));

  pw_window #(.LIMIT(WIN_LIMIT), .W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .restart_i(strobe_ev), .late_o(late));

  pw_poll #(.DATA_W(DATA_W), .LIMIT(POLL_LIMIT), .W(TO_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_ev), .sample_i(sample_ev),
    .din_i(mem_din_i), .ref_msb_i(data_q[DATA_W-1]),
    .match_o(match), .expired_o(expired));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      tmr_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (count_ok(count_i)) begin
            code_q  <= ERR_NONE;
            cnt_q   <= count_i;
            idx_q   <= '0;
            first_q <= 1'b1;
            state_q <= ST_WAIT;
          end else begin
            code_q <= ERR_COUNT;
            err_q  <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (late && !first_q) begin
            code_q  <= ERR_BREAK;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (accept) begin
            data_q  <= byte_data_i;
            tmr_q   <= '0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP, ST_STROBE, ST_RECOV: begin
          if (!tmr_end) tmr_q <= tmr_q + 1'b1;
          else begin
            tmr_q <= '0;
            if (state_q == ST_SETUP) state_q <= ST_STROBE;
            else if (state_q == ST_STROBE) begin
              state_q <= ST_RECOV;
              first_q <= 1'b0;
            end else if (last_byte) state_q <= ST_REL;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_REL: begin
          tmr_q   <= '0;
          state_q <= ST_READ;
        end
        ST_READ: begin
          if (!tmr_end) tmr_q <= tmr_q + 1'b1;
          else if (match) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (expired) begin
            code_q  <= ERR_TIMEOUT;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else state_q <= ST_GAP;
        end
        default: begin
          tmr_q   <= '0;
          state_q <= ST_READ;
        end
      endcase
    end
  end

  assign byte_ready_o  = (state_q == ST_WAIT) && !(late && !first_q);
  assign mem_dout_o    = data_q;
  assign mem_dout_en_o = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_RECOV);
  assign mem_ce_n_o    = !(mem_dout_en_o || (state_q == ST_READ));
  assign mem_oe_n_o    = (state_q != ST_READ);
  assign mem_we_n_o    = (state_q != ST_STROBE);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_code_o    = code_q;

  // port-level event trackers for the checks below
  logic             prev_we_q, we_fall, seen_fall_q;
  logic [GAP_W-1:0] gap_q;
  logic [RUN_W-1:0] low_run_q;
  assign we_fall = prev_we_q && !mem_we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we_q   <= 1'b1;
      seen_fall_q <= 1'b0;
      gap_q       <= '0;
      low_run_q   <= '0;
    end else begin
      prev_we_q <= mem_we_n_o;
      low_run_q <= mem_we_n_o ? '0 : ((low_run_q == RUN_W'(T_WPW + 1)) ? low_run_q : low_run_q + 1'b1);
      if (gap_q != GAP_W'(BLC_CYC)) gap_q <= gap_q + 1'b1;
      if (!busy_o) seen_fall_q <= 1'b0;
      if (we_fall) begin
        gap_q       <= GAP_W'(1);
        seen_fall_q <= 1'b1;
      end
    end
  end

  // R6
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (mem_oe_n_o && mem_dout_en_o));
  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (low_run_q == RUN_W'(T_WPW)));
  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && seen_fall_q) |-> (gap_q < GAP_W'(BLC_CYC)));
  // R9
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n_o |-> (!mem_dout_en_o && $past(!mem_dout_en_o) && mem_we_n_o));
  // R3
  page_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(!mem_oe_n_o) && !busy_o));
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int TS = 2, TW = 4, TH = 2, TR = 3, BLC = 40, PLIM = 300;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, byte_valid_i = 0;
  logic [10:0] base_addr_i = '0;
  logic [4:0]  count_i = '0;
  logic [7:0]  byte_data_i = '0;
  logic byte_ready_o, mem_dout_en_o, mem_ce_n_o, mem_oe_n_o, mem_we_n_o;
  logic busy_o, done_o, err_o;
  logic [1:0]  err_code_o;
  logic [10:0] mem_addr_o;
  logic [7:0]  mem_dout_o, mem_din_i;

  always #10 clk = ~clk;

  eeprom_page_writer #(.T_SETUP(TS), .T_WPW(TW), .T_WPH(TH), .T_RD(TR),
                       .BLC_CYC(BLC), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .count_i(count_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .mem_addr_o(mem_addr_o), .mem_dout_o(mem_dout_o),
    .mem_dout_en_o(mem_dout_en_o), .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_din_i(mem_din_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o));

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and port monitor (all sampled at negedge)
  logic [7:0]  mem [2048];
  logic [10:0] last_addr = '0;
  int prog_cyc = 20, prog_left = 0;
  int nrise = 0, nreads = 0, ev_done_n = 0, ev_prog = 0, ev_code = 0;
  bit ev_err = 0;
  int v_setup = 0, v_hold = 0, v_width = 0, v_gap = 0, v_poll = 0, v_page = 0;
  logic [10:0] rise_addr [32];
  logic [7:0]  rise_data [32];
  logic prev_we = 1, prev_oe = 1, prev_den = 0, prev_busy = 0;
  logic [10:0] prev_addr = '0, hold_addr = '0;
  logic [7:0]  prev_dout = '0, hold_dout = '0;
  int low_run = 0, set_run = 0, hold_left = 0, gap = 0;
  bit seen_fall = 0;

  assign mem_din_i = (!mem_ce_n_o && !mem_oe_n_o) ?
      ((prog_left > 0 && mem_addr_o == last_addr) ? {~mem[mem_addr_o][7], mem[mem_addr_o][6:0]}
                                                  : mem[mem_addr_o]) : 8'h00;

  always @(negedge clk) begin
    if (prog_left > 0) prog_left--;
    if (done_o) begin ev_done_n++; ev_prog = prog_left; end
    if (err_o) begin ev_err = 1; ev_code = int'(err_code_o); end
    if (!mem_oe_n_o && (mem_dout_en_o || !mem_we_n_o || prev_den || mem_ce_n_o)) v_poll++;
    if (!mem_oe_n_o && prev_oe) nreads++;
    if (busy_o && prev_busy && mem_addr_o[10:4] != prev_addr[10:4]) v_page++;
    if (prev_we && !mem_we_n_o) begin
      if (set_run < TS) v_setup++;
      if (seen_fall && gap >= BLC) v_gap++;
      gap = 0; seen_fall = 1;
    end
    if (!mem_we_n_o) low_run++;
    if (mem_we_n_o && !prev_we) begin
      if (low_run != TW) v_width++;
      if (nrise < 32) begin rise_addr[nrise] = mem_addr_o; rise_data[nrise] = mem_dout_o; end
      nrise++;
      mem[mem_addr_o] = mem_dout_o;
      last_addr = mem_addr_o;
      prog_left = prog_cyc;
      hold_addr = mem_addr_o; hold_dout = mem_dout_o;
      hold_left = TH;
    end
    if (mem_we_n_o) low_run = 0;
    if (hold_left > 0) begin
      if (!mem_oe_n_o || !mem_dout_en_o || mem_addr_o != hold_addr || mem_dout_o != hold_dout) v_hold++;
      hold_left--;
    end
    if (mem_dout_en_o && mem_oe_n_o && !mem_ce_n_o)
      set_run = (prev_den && mem_addr_o == prev_addr && mem_dout_o == prev_dout) ? set_run + 1 : 1;
    else set_run = 0;
    gap++;
    if (!busy_o) seen_fall = 0;
    prev_we = mem_we_n_o; prev_oe = mem_oe_n_o; prev_den = mem_dout_en_o;
    prev_busy = busy_o; prev_addr = mem_addr_o; prev_dout = mem_dout_o;
  end

  function automatic logic [7:0] dat(input logic [10:0] b, input int k);
    return 8'(b * 7 + k * 29 + 8'h5A);
  endfunction

  function automatic logic [10:0] eaddr(input logic [10:0] b, input int k);
    return {b[10:4], 4'(b[3:0] + k)};
  endfunction

  task automatic clear_ev();
    nrise = 0; nreads = 0; ev_done_n = 0; ev_err = 0; ev_code = 0;
    v_setup = 0; v_hold = 0; v_width = 0; v_gap = 0; v_poll = 0; v_page = 0;
  endtask

  task automatic do_page(input logic [10:0] b, input int cnt, input int stall_k,
                         input int stall_n, input int poke_k, input int prog);
    prog_cyc = prog;
    clear_ev();
    @(negedge clk);
    start_i = 1; base_addr_i = b; count_i = 5'(cnt);
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < cnt && k < 17; k++) begin
      if (k == poke_k) begin
        start_i = 1; count_i = 5'd0;
        @(negedge clk);
        start_i = 0;
      end
      while (!byte_ready_o && busy_o) @(negedge clk);
      if (!busy_o) break;
      if (k == stall_k) repeat (stall_n) @(negedge clk);
      byte_valid_i = 1; byte_data_i = dat(b, k);
      @(negedge clk);
      byte_valid_i = 0;
    end
    for (int g = 0; g < 2000 && ev_done_n == 0 && !ev_err; g++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_good(input logic [10:0] b, input int cnt, input string tag);
    chk(ev_done_n == 1 && !ev_err, {tag, " R10 done once"}, ev_done_n, 1);
    chk(ev_prog == 0, "R10 done only after model finished", ev_prog, 0);
    chk(ev_code == 0 && err_code_o == 2'd0, "R12/R11 no error code", int'(err_code_o), 0);
    chk(nrise == cnt, {tag, " R4 strobe count"}, nrise, cnt);
    for (int k = 0; k < cnt && k < 32; k++) begin
      chk(rise_addr[k] == eaddr(b, k), "R3 byte address", int'(rise_addr[k]), int'(eaddr(b, k)));
      chk(rise_data[k] == dat(b, k), "R4 byte data", int'(rise_data[k]), int'(dat(b, k)));
      chk(mem[eaddr(b, k)] == dat(b, k), "R4 stored byte", int'(mem[eaddr(b, k)]), int'(dat(b, k)));
    end
    chk(v_page == 0, "R3 page bits constant", v_page, 0);
    chk(v_setup == 0 && v_hold == 0, "R5 setup/hold", v_setup + v_hold, 0);
    chk(v_width == 0, "R6 strobe width", v_width, 0);
    chk(v_gap == 0, "R7 strobe spacing", v_gap, 0);
    chk(v_poll == 0 && nreads >= 1, "R9 poll read cycles", v_poll, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n_o && mem_oe_n_o && mem_we_n_o, "R1 strobes high", 0, 1);
    chk(!mem_dout_en_o && !byte_ready_o && !busy_o, "R1 idle outputs", int'(busy_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 bad counts
    foreach (count_i[i]) ;
    for (int c = 0; c < 3; c++) begin
      int bad;
      bad = (c == 0) ? 0 : (c == 1) ? 17 : 31;
      clear_ev();
      @(negedge clk); start_i = 1; count_i = 5'(bad); base_addr_i = 11'h120;
      @(negedge clk); start_i = 0;
      repeat (6) @(negedge clk);
      chk(ev_err && ev_code == 1, "R2 bad count error code", ev_code, 1);
      chk(nrise == 0 && !busy_o, "R2 no strobe on bad count", nrise, 0);
    end

    // R3 R4 R5 R6 R7 R9 R10 sweep of counts and offsets
    for (int cnt = 1; cnt <= 16; cnt++) begin
      for (int o = 0; o < 4; o++) begin
        logic [10:0] b;
        b = 11'((cnt * 97 + o * 211) & 11'h7F0) | 11'((o * 5 + cnt) & 15);
        do_page(b, cnt, -1, 0, -1, (o == 0) ? 0 : 15 + o * 7);
        check_good(b, cnt, "sweep");
      end
    end

    // R8 stall at the window boundary
    for (int s = 28; s <= 32; s++) begin
      bit ok;
      ok = (TW + TH + s) <= (BLC - TS - 2);
      do_page(11'h350, 3, 1, s, -1, 10);
      if (ok) check_good(11'h350, 3, "R8 stall inside window");
      else begin
        chk(ev_err && ev_code == 2, "R8 page break code", ev_code, 2);
        chk(nrise == 1 && ev_done_n == 0, "R8 no strobe after break", nrise, 1);
      end
    end
    // R8 long stall before first byte is allowed
    do_page(11'h4A3, 4, 0, 3 * BLC, -1, 10);
    check_good(11'h4A3, 4, "R8 first byte stall");

    // R11 timeout when programming never finishes
    do_page(11'h611, 2, -1, 0, -1, 100000);
    for (int g = 0; g < 600 && !ev_err; g++) @(negedge clk);
    chk(ev_err && ev_code == 3, "R11 timeout code", ev_code, 3);
    chk(ev_done_n == 0, "R11 no done on timeout", ev_done_n, 0);
    chk(v_poll == 0 && nreads >= 2, "R9 repeated poll reads", nreads, 2);
    prog_left = 0;

    // R12 start while busy ignored
    do_page(11'h2C7, 5, -1, 0, 2, 12);
    check_good(11'h2C7, 5, "R12 start while busy");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule